// File: doc/BRIEF.md
# Pixel Bit-Depth Reducer with Spatial Dither

This block takes a stream of pixels with three 12-bit channels (RGB or YCbCr) and brings each channel down to a smaller output depth. One pixel moves per clock on a valid/ready stream, and a start-of-frame flag marks the first pixel of each frame. The reduced value stays left-aligned in the 12-bit field, and the bits it discards are zero. Three kinds of reduction are available:

- plain truncation;
- truncation with round-to-nearest;
- spatial dither, where a pseudo-random value is added before truncation.

The noise comes from one 28-bit linear feedback shift register per channel, and each channel has its own seed. The registers can be reloaded from their seeds on every frame. They can also be loaded once and then left to run freely, with a frame counter that wraps and disturbs the pattern from frame to frame. A shared-generator option makes all three channels take their noise from the first channel's register.

Configuration arrives on static inputs. The block samples it when it accepts a start-of-frame pixel and holds it until the next one. The output is registered, so a pixel leaves one cycle after it is accepted.

Top module: `pbd_reducer`

## Requirements
- R1: With dither disabled (or dither depth code 3) and truncation disabled, every channel passes through unchanged. An accepted pixel appears on the output in the cycle after the edge that accepted it.
- R2: With truncation enabled and rounding off, the low bits of each channel are cleared. Depth code 0 keeps the top 6 bits and clears the low 6. Depth code 1 keeps the top 8 bits and clears the low 4.
- R3: With truncation and rounding enabled, half of one output LSB is added before the low bits are cleared. That is 32 for depth code 0 and 8 for depth code 1. The sum saturates at 4095, so a saturated channel becomes all ones in its kept bits.
- R4: With dither enabled and dither depth code 0, 1 or 2, the block adds noise to the channel. The noise is D bits wide, where D is 6, 4 or 2 (keeping 6, 8 or 10 bits). The sum saturates at 4095 and the low D bits are then cleared. Dither takes priority over truncation. Dither depth code 3 disables dither, and the truncation settings then apply.
- R5: Each noise generator is a 28-bit register with next state {s[26:0], s[27]^s[2]}, which is the polynomial x^28+x^3+1. A channel's noise is the low D bits of its current state XOR the frame perturbation. Every generator advances once for each accepted pixel.
- R6: The seed bus holds one 28-bit seed per channel; channel c (pixel bits [12c+11:12c]) uses seed bits [28c+27:28c]. With frame-random off, every start-of-frame pixel uses the seed itself as the current state, and so every frame repeats the same pattern.
- R7: The first start-of-frame pixel after reset always loads the seeds. With frame-random on, later frames do not reload the generators. Instead, a frame counter starts at 0 and steps by one on each later start-of-frame pixel. It wraps after 15 for dither depth codes 0 and 1, and after 3 for code 2. The counter shifted left by 2 (codes 0 and 1) or by 1 (code 2) is XORed into the noise. With frame-random off, the counter is 0.
- R8: With the shared-generator option, channel c uses bits [8c+D-1:8c] of channel 0's current state in place of its own generator's state.
- R9: Configuration inputs are sampled on the accepted start-of-frame pixel and apply to that pixel. Changes to them between frame starts have no effect on the pixels of the current frame.
- R10: in_ready is high when the output register is empty or out_ready is high. While out_valid is high and out_ready is low, out_pix and out_sof hold steady.
- R11: During and right after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_pix | input | 36 | Three 12-bit channels, channel 0 in the low bits |
| cfg_trunc_en | input | 1 | Truncation enable |
| cfg_trunc_round | input | 1 | Round to nearest before truncation |
| cfg_trunc_depth | input | 1 | Truncation depth: 0 keeps 6 bits, 1 keeps 8 bits |
| cfg_dith_en | input | 1 | Spatial dither enable |
| cfg_dith_depth | input | 2 | Dither depth: 0/1/2 keep 6/8/10 bits, 3 disables dither |
| cfg_frame_rand | input | 1 | Load seeds once and perturb with the frame counter |
| cfg_shared_rand | input | 1 | All channels draw from channel 0's generator |
| seed_bus | input | 84 | Three 28-bit seeds, channel 0 in the low bits |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_pix | output | 36 | Reduced pixel, kept bits left-aligned, discarded bits zero |

## Verification
The assertions check on every cycle the properties that hold no matter what the noise is:

- the output is held steady under backpressure;
- a pixel passes unchanged when no reduction is selected;
- discarded bits are zero, and a result never falls below the truncated input;
- the latched configuration moves only on a start-of-frame pixel;
- the frame counter stays inside its bound;
- a running generator never collapses to zero.

Only the bench's scenarios can show the exact noise values. It compares them against an independent model across the following cases:

- per-frame reseeding;
- the frame counter wrapping at 3 and at 15;
- slices of the shared generator;
- rounding saturation at full scale;
- dither overriding truncation;
- configuration changes in mid-frame, which must be ignored.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    localparam int PIX_W = 12;
    localparam int RNG_W = 28;

    typedef enum logic [1:0] {
        QM_PASS   = 2'd0,
        QM_TRUNC  = 2'd1,
        QM_ROUND  = 2'd2,
        QM_DITHER = 2'd3
    } qmode_e;

    typedef struct packed {
        logic       trunc_en;
        logic       trunc_round;
        logic       trunc_depth;
        logic       dith_en;
        logic [1:0] dith_depth;
        logic       frame_rand;
        logic       shared_rand;
    } fmt_cfg_t;

    // Generator step, x^28 + x^3 + 1
    function automatic logic [RNG_W-1:0] rng_next(input logic [RNG_W-1:0] s);
        return {s[RNG_W-2:0], s[RNG_W-1] ^ s[2]};
    endfunction

    // Kept bits for a dither depth code (3 means no dither)
    function automatic int kept_for_dither(input logic [1:0] code);
        case (code)
            2'd0:    return 6;
            2'd1:    return 8;
            2'd2:    return 10;
            default: return PIX_W;
        endcase
    endfunction

    function automatic int kept_for_trunc(input logic code);
        return code ? 8 : 6;
    endfunction

    // Frame counter wrap value for a dither depth code
    function automatic logic [3:0] fc_limit(input logic [1:0] code);
        case (code)
            2'd0, 2'd1: return 4'd15;
            2'd2:       return 4'd3;
            default:    return 4'd0;
        endcase
    endfunction

    // Left shift applied to the frame counter before it meets the noise
    function automatic logic [1:0] fc_shift(input logic [1:0] code);
        case (code)
            2'd0, 2'd1: return 2'd2;
            2'd2:       return 2'd1;
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/pbd_noise.sv
module pbd_noise
    import pbd_pkg::*;
#(
    parameter int NUM_CH       = 3,
    parameter int CH_W         = PIX_W,
    parameter int GEN_W        = RNG_W,
    parameter int SHARE_STRIDE = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     take,
    input  logic                     sof,
    input  logic                     frame_rand,
    input  logic                     shared,
    input  logic [1:0]               depth,
    input  logic [NUM_CH*GEN_W-1:0]  seeds,
    output logic [NUM_CH*CH_W-1:0]   noise
);

    logic [GEN_W-1:0] st_q   [NUM_CH];
    logic [GEN_W-1:0] st_cur [NUM_CH];
    logic             seeded_q;
    logic             load_now;
    logic [3:0]       fc_q;
    logic [3:0]       fc_cur;
    logic [3:0]       fc_max;
    logic [1:0]       fc_sh;
    logic [CH_W-1:0]  perturb;

    assign load_now = sof && (!frame_rand || !seeded_q);
    assign fc_max   = frame_rand ? fc_limit(depth) : 4'd0;
    assign fc_sh    = frame_rand ? fc_shift(depth) : 2'd0;

    always_comb begin
        fc_cur = fc_q;
        if (sof) begin
            if (seeded_q && frame_rand)
                fc_cur = (fc_q >= fc_max) ? 4'd0 : fc_q + 4'd1;
            else
                fc_cur = 4'd0;
        end
    end

    assign perturb = CH_W'(fc_cur) << fc_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            seeded_q <= 1'b0;
            fc_q     <= 4'd0;
        end else if (take) begin
            fc_q <= fc_cur;
            if (sof)
                seeded_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic [GEN_W-1:0] src;

        assign st_cur[g] = load_now ? seeds[g*GEN_W +: GEN_W] : st_q[g];
        assign src       = shared ? (st_cur[0] >> (g*SHARE_STRIDE)) : st_cur[g];
        assign noise[g*CH_W +: CH_W] = src[CH_W-1:0] ^ perturb;

        always_ff @(posedge clk) begin
            if (rst)
                st_q[g] <= '0;
            else if (take)
                st_q[g] <= rng_next(st_cur[g]);
        end
    end

    // R7: a depth-2 frame start with frame-random keeps the counter within 0..3
    p_fc_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (take && sof && frame_rand && depth == 2'd2) |=> (fc_q <= 4'd3))
        else $error("frame counter beyond depth-2 wrap");

    // R6: frame-random off forces the counter to zero at frame start
    p_fc_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (take && sof && !frame_rand) |=> (fc_q == 4'd0))
        else $error("frame counter not cleared");

    // R5: a non-zero generator that is not reloaded stays non-zero
    p_gen_alive_r5: assert property (@(posedge clk) disable iff (rst)
        (take && !load_now && st_q[0] != '0) |=> (st_q[0] != '0))
        else $error("generator collapsed to zero");

endmodule

// File: rtl/pbd_quant.sv
module pbd_quant
    import pbd_pkg::*;
#(
    parameter int CH_W = PIX_W,
    parameter int DW   = $clog2(CH_W + 1)
) (
    input  qmode_e           mode,
    input  logic [DW-1:0]    drop,
    input  logic [CH_W-1:0]  pix,
    input  logic [CH_W-1:0]  noise,
    output logic [CH_W-1:0]  res
);

    logic [CH_W-1:0] mask;
    logic [CH_W-1:0] half;
    logic [CH_W-1:0] add;
    logic [CH_W:0]   sum;
    logic [CH_W-1:0] sat;

    always_comb begin
        mask = (CH_W'(1) << drop) - CH_W'(1);
        half = (drop == '0) ? '0 : (CH_W'(1) << (drop - DW'(1)));
        case (mode)
            QM_ROUND:  add = half;
            QM_DITHER: add = noise & mask;
            default:   add = '0;
        endcase
        sum = {1'b0, pix} + {1'b0, add};
        sat = sum[CH_W] ? '1 : sum[CH_W-1:0];
        res = (mode == QM_PASS) ? pix : (sat & ~mask);
    end

endmodule

// File: rtl/pbd_reducer.sv
module pbd_reducer
    import pbd_pkg::*;
#(
    parameter int NUM_CH       = 3,
    parameter int CH_W         = PIX_W,
    parameter int GEN_W        = RNG_W,
    parameter int SHARE_STRIDE = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic                     in_sof,
    input  logic [NUM_CH*CH_W-1:0]   in_pix,
    input  logic                     cfg_trunc_en,
    input  logic                     cfg_trunc_round,
    input  logic                     cfg_trunc_depth,
    input  logic                     cfg_dith_en,
    input  logic [1:0]               cfg_dith_depth,
    input  logic                     cfg_frame_rand,
    input  logic                     cfg_shared_rand,
    input  logic [NUM_CH*GEN_W-1:0]  seed_bus,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     out_sof,
    output logic [NUM_CH*CH_W-1:0]   out_pix
);

    localparam int DW = $clog2(CH_W + 1);

    fmt_cfg_t                cfg_live;
    fmt_cfg_t                cfg_q;
    fmt_cfg_t                cfg_eff;
    logic                    sof_now;
    logic                    take;
    qmode_e                  mode;
    logic [DW-1:0]           drop;
    logic [CH_W-1:0]         drop_mask;
    logic [NUM_CH*CH_W-1:0]  noise;
    logic [NUM_CH*CH_W-1:0]  reduced;

    assign cfg_live = '{trunc_en:    cfg_trunc_en,
                        trunc_round: cfg_trunc_round,
                        trunc_depth: cfg_trunc_depth,
                        dith_en:     cfg_dith_en,
                        dith_depth:  cfg_dith_depth,
                        frame_rand:  cfg_frame_rand,
                        shared_rand: cfg_shared_rand};

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;
    assign sof_now  = in_valid && in_sof;
    assign cfg_eff  = sof_now ? cfg_live : cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (take && in_sof)
            cfg_q <= cfg_live;
    end

    // Mode and discard width selection: dither outranks truncation
    always_comb begin
        if (cfg_eff.dith_en && cfg_eff.dith_depth != 2'd3) begin
            mode = QM_DITHER;
            drop = DW'(CH_W - kept_for_dither(cfg_eff.dith_depth));
        end else if (cfg_eff.trunc_en) begin
            mode = cfg_eff.trunc_round ? QM_ROUND : QM_TRUNC;
            drop = DW'(CH_W - kept_for_trunc(cfg_eff.trunc_depth));
        end else begin
            mode = QM_PASS;
            drop = '0;
        end
    end

    assign drop_mask = (CH_W'(1) << drop) - CH_W'(1);

    pbd_noise #(
        .NUM_CH       (NUM_CH),
        .CH_W         (CH_W),
        .GEN_W        (GEN_W),
        .SHARE_STRIDE (SHARE_STRIDE)
    ) noise_i (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .sof        (sof_now),
        .frame_rand (cfg_eff.frame_rand),
        .shared     (cfg_eff.shared_rand),
        .depth      (cfg_eff.dith_depth),
        .seeds      (seed_bus),
        .noise      (noise)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_quant
        pbd_quant #(
            .CH_W (CH_W),
            .DW   (DW)
        ) quant_i (
            .mode  (mode),
            .drop  (drop),
            .pix   (in_pix[c*CH_W +: CH_W]),
            .noise (noise[c*CH_W +: CH_W]),
            .res   (reduced[c*CH_W +: CH_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_pix   <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_sof   <= in_sof;
            out_pix   <= reduced;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R10: stalled output holds
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_sof)))
        else $error("output changed while stalled");

    // R1: pass mode leaves the pixel untouched, one cycle later
    p_pass_r1: assert property (@(posedge clk) disable iff (rst)
        (take && mode == QM_PASS) |=> (out_valid && out_pix == $past(in_pix)))
        else $error("pass-through altered pixel");

    // R2: discarded bits are zero after any reduction
    p_lowbits_r2: assert property (@(posedge clk) disable iff (rst)
        (take && mode != QM_PASS) |=> ((out_pix[CH_W-1:0] & $past(drop_mask)) == '0))
        else $error("discarded bits not cleared");

    // R3: rounding or dither never lands below the plain truncation
    p_floor_r3: assert property (@(posedge clk) disable iff (rst)
        (take && mode != QM_PASS) |=>
            (out_pix[CH_W-1:0] >= ($past(in_pix[CH_W-1:0]) & ~$past(drop_mask))))
        else $error("reduced value below truncation");

    // R9: latched configuration moves only on an accepted frame start
    p_cfg_latch_r9: assert property (@(posedge clk) disable iff (rst)
        !(take && in_sof) |=> $stable(cfg_q))
        else $error("configuration changed mid-frame");

endmodule

// File: tb/pbd_reducer_tb_top.sv
module pbd_reducer_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_sof = 1'b0;
    logic [35:0]  in_pix = '0;
    logic         c_te = 0, c_tr = 0, c_tp = 0, c_de = 0, c_fr = 0, c_sh = 0;
    logic [1:0]   c_dd = 2'd0;
    logic [83:0]  seed_bus;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic         out_sof;
    logic [35:0]  out_pix;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit bp_on  = 0;

    logic [35:0] exp_q[$];
    string       tag_q[$];

    // model state
    logic        m_te = 0, m_tr = 0, m_tp = 0, m_de = 0, m_fr = 0, m_sh = 0;
    logic [1:0]  m_dd = 0;
    logic [27:0] m_gen [3];
    logic [3:0]  m_fc = 0;
    bit          m_seeded = 0;

    always #4 clk = ~clk;

    pbd_reducer dut_i (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_ready (in_ready), .in_sof (in_sof), .in_pix (in_pix),
        .cfg_trunc_en (c_te), .cfg_trunc_round (c_tr), .cfg_trunc_depth (c_tp),
        .cfg_dith_en (c_de), .cfg_dith_depth (c_dd), .cfg_frame_rand (c_fr),
        .cfg_shared_rand (c_sh), .seed_bus (seed_bus),
        .out_valid (out_valid), .out_ready (out_ready), .out_sof (out_sof), .out_pix (out_pix)
    );

    function automatic logic [11:0] quant(input logic [11:0] p, input int kind,
                                          input int d, input logic [11:0] n);
        int mask = (1 << d) - 1;
        int add  = 0;
        int s;
        if (kind == 2) add = 1 << (d - 1);
        if (kind == 3) add = int'(n) & mask;
        s = int'(p) + add;
        if (s > 4095) s = 4095;
        if (kind != 0) s = s & ~mask;
        return 12'(s);
    endfunction

    function automatic int kept_d(input logic [1:0] code);
        return (code == 0) ? 6 : (code == 1) ? 8 : (code == 2) ? 10 : 12;
    endfunction

    task automatic model_push(input logic [35:0] pix, input logic sof, input string tag);
        logic [27:0] cur [3];
        logic [27:0] src;
        logic [3:0]  fc, fmax;
        int          sw, d, kind;
        bit          load;
        logic [35:0] e;
        if (sof) begin
            m_te = c_te; m_tr = c_tr; m_tp = c_tp; m_de = c_de;
            m_dd = c_dd; m_fr = c_fr; m_sh = c_sh;
        end
        load = sof && (!m_fr || !m_seeded);
        for (int c = 0; c < 3; c++)
            cur[c] = load ? seed_bus[c*28 +: 28] : m_gen[c];
        fmax = !m_fr ? 4'd0 : (m_dd < 2) ? 4'd15 : (m_dd == 2) ? 4'd3 : 4'd0;
        sw   = !m_fr ? 0 : (m_dd < 2) ? 2 : (m_dd == 2) ? 1 : 0;
        if (sof) fc = (m_seeded && m_fr) ? ((m_fc >= fmax) ? 4'd0 : m_fc + 4'd1) : 4'd0;
        else     fc = m_fc;
        if (m_de && m_dd != 2'd3) begin kind = 3; d = 12 - kept_d(m_dd); end
        else if (m_te) begin kind = m_tr ? 2 : 1; d = m_tp ? 4 : 6; end
        else begin kind = 0; d = 0; end
        for (int c = 0; c < 3; c++) begin
            src = m_sh ? (cur[0] >> (8*c)) : cur[c];
            e[c*12 +: 12] = quant(pix[c*12 +: 12], kind, d,
                                  src[11:0] ^ (12'(fc) << sw));
        end
        for (int c = 0; c < 3; c++)
            m_gen[c] = {cur[c][26:0], cur[c][27] ^ cur[c][2]};
        m_fc = fc;
        if (sof) m_seeded = 1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [35:0] pix, input logic sof, input string tag);
        bit sent = 0;
        in_pix = pix; in_sof = sof; in_valid = 1'b1;
        while (!sent) begin
            @(negedge clk);
            if (in_ready) begin
                model_push(pix, sof, tag);
                sent = 1;
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    function automatic logic [35:0] mk(input int k);
        if (k % 5 == 3) return 36'hFFF_FFE_FFF;
        if (k % 7 == 4) return 36'h000_001_000;
        return {12'(k*1237 + 91), 12'(k*731 + 2040), 12'(k*2897 + 4000)};
    endfunction

    task automatic send_frame(input int n, input int base, input string tag);
        for (int k = 0; k < n; k++) send(mk(base + k), k == 0, tag);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        @(posedge clk); #1;
    endtask

    task automatic set_cfg(input logic te, input logic tr, input logic tp, input logic de,
                           input logic [1:0] dd, input logic fr, input logic sh);
        c_te = te; c_tr = tr; c_tp = tp; c_de = de; c_dd = dd; c_fr = fr; c_sh = sh;
    endtask

    // Scoreboard monitor
    initial begin
        bit          stalled = 0;
        logic [35:0] held    = '0;
        logic [35:0] e;
        string       t;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (stalled) begin
                    checks++;
                    if (!(out_valid && out_pix == held)) begin
                        errors++;
                        $display("FAIL R10: stalled output got %h valid %0b expected %h valid 1",
                                 out_pix, out_valid, held);
                    end
                end
                if (out_valid && out_ready) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R1: unexpected output %h expected none", out_pix);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if (out_pix !== e) begin
                            errors++;
                            $display("FAIL %s: got %h expected %h", t, out_pix, e);
                        end
                    end
                end
                stalled = out_valid && !out_ready;
                held    = out_pix;
            end
        end
    end

    // Backpressure pattern
    initial begin
        logic [3:0] bp_cnt = 0;
        forever begin
            @(posedge clk); #1;
            if (bp_on) begin
                out_ready = bp_cnt[0] ^ bp_cnt[2];
                bp_cnt++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        seed_bus = {28'h2468ACE, 28'h13579BD, 28'h0A5C3E1};
        for (int c = 0; c < 3; c++) m_gen[c] = '0;
        repeat (5) @(posedge clk);
        #1;
        checks++;
        if (!(out_valid == 0 && in_ready == 1)) begin
            errors++;
            $display("FAIL R11: in reset valid=%0b ready=%0b expected 0 1", out_valid, in_ready);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (!(out_valid == 0 && in_ready == 1)) begin
            errors++;
            $display("FAIL R11: after reset valid=%0b ready=%0b expected 0 1", out_valid, in_ready);
        end
        @(posedge clk); #1;

        // R1: pass-through and latency
        set_cfg(0, 0, 0, 0, 2'd0, 0, 0);
        send_frame(8, 0, "R1");
        drain();
        send(36'h8A5_3C1_7FF, 1'b1, "R1");
        @(negedge clk);
        checks++;
        if (!(out_valid && out_pix == 36'h8A5_3C1_7FF)) begin
            errors++;
            $display("FAIL R1: latency got valid=%0b %h expected valid=1 8a53c17ff", out_valid, out_pix);
        end
        @(posedge clk); #1;

        // R2: truncation, both depths
        set_cfg(1, 0, 0, 0, 2'd0, 0, 0);
        send_frame(6, 10, "R2");
        set_cfg(1, 0, 1, 0, 2'd0, 0, 0);
        send_frame(6, 20, "R2");

        // R3: rounding with saturation
        set_cfg(1, 1, 1, 0, 2'd0, 0, 0);
        send(36'hFFF_FF8_007, 1'b1, "R3");
        send(36'hFF7_800_FFC, 1'b0, "R3");
        set_cfg(1, 1, 0, 0, 2'd0, 0, 0);
        send(36'hFE0_01F_020, 1'b1, "R3");
        send_frame(5, 30, "R3");

        // R4/R5/R6: per-channel dither, reseed every frame
        set_cfg(0, 0, 0, 1, 2'd0, 0, 0);
        send_frame(7, 40, "R5");
        send_frame(7, 40, "R6");
        set_cfg(1, 0, 0, 1, 2'd1, 0, 0);
        send_frame(6, 50, "R4");
        set_cfg(1, 0, 1, 1, 2'd2, 0, 0);
        send_frame(6, 60, "R4");
        set_cfg(1, 0, 1, 1, 2'd3, 0, 0);
        send_frame(5, 70, "R4");

        // R7: free-running generators with frame counter
        set_cfg(0, 0, 0, 1, 2'd2, 1, 0);
        for (int f = 0; f < 7; f++) send_frame(3, 80 + f, "R7");
        set_cfg(0, 0, 0, 1, 2'd0, 1, 0);
        for (int f = 0; f < 18; f++) send_frame(2, 100 + f, "R7");

        // R8: shared generator
        set_cfg(0, 0, 0, 1, 2'd0, 0, 1);
        send_frame(6, 130, "R8");
        set_cfg(0, 0, 0, 1, 2'd1, 1, 1);
        send_frame(4, 140, "R8");

        // R9: mid-frame configuration changes ignored
        set_cfg(0, 0, 0, 0, 2'd0, 0, 0);
        send(mk(150), 1'b1, "R9");
        set_cfg(1, 1, 0, 1, 2'd0, 1, 1);
        send(mk(151), 1'b0, "R9");
        send(36'hFFF_7FF_123, 1'b0, "R9");
        set_cfg(1, 0, 0, 0, 2'd0, 0, 0);
        send(mk(153), 1'b1, "R9");
        set_cfg(0, 0, 0, 1, 2'd2, 0, 0);
        send(36'h0FF_F0F_ABC, 1'b0, "R9");
        drain();

        // R10: backpressure
        set_cfg(0, 0, 0, 1, 2'd1, 0, 0);
        bp_on = 1;
        send_frame(16, 160, "R10");
        set_cfg(1, 1, 1, 0, 2'd0, 0, 0);
        send_frame(10, 180, "R10");
        drain();
        bp_on = 0;
        @(posedge clk); #1;
        out_ready = 1'b1;
        drain();

        repeat (4) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule